// File: doc/BRIEF.md
# Indexed Addressing Postbyte Address Generator

This block turns the indexed-addressing postbyte of a 16-bit-address, 8-bit-data microcontroller core into an effective address. On a start pulse it decodes the postbyte and latches the chosen base register: X, Y, SP or PC. It then builds an offset from one of several sources: the postbyte itself, the A/B accumulators, the D pair, or one or two extension bytes taken from the fetch port. For the two indirect forms it reads a 16-bit word from memory and uses that word as the final address. The auto increment and decrement forms also return a write-back of the updated index register.

The sequencer is a state machine with five states. IDLE waits for `start`. FETCH_HI takes the high extension byte. FETCH_LO takes the low byte, or the only byte in the 9-bit form. READ performs the indirect word read. DONE presents the result for one cycle.

The transitions are:
- IDLE moves to FETCH_HI for the 16-bit offset forms, to FETCH_LO for the 9-bit form, to READ for the D-indirect form, and straight to DONE for everything else, including rejected forms.
- FETCH_HI moves to FETCH_LO on `fetch_ack`.
- FETCH_LO moves to READ on `fetch_ack` for the 16-bit indirect form, and to DONE otherwise.
- READ moves to DONE on `mem_ack`.
- DONE always returns to IDLE.

The postbyte and the register inputs are sampled only in the cycle where `start` is high in IDLE. A `start` in any other state is ignored.

Top module: `idx_agen`

## Requirements
- R1: Postbyte bit 5 = 0 selects the short form. Base register = bits 7:6, with the encoding 0 X, 1 Y, 2 SP, 3 PC. Effective address = base + bits 4:0 taken as a signed 5-bit value (range -16..15), modulo 2^16.
- R2: Bit 5 = 1 with bits 7:6 not equal to 11 selects an auto form on the register named by bits 7:6. The step is bits 3:0 minus 16 when bit 3 = 1 (a step of -8..-1), and bits 3:0 plus 1 otherwise (a step of +1..+8).
- R3: In an auto form, `wb_en` is high in the done cycle. `wb_sel` equals the base select and `wb_value` = base + step. The effective address is `wb_value` when bit 4 = 0 (pre-update) and the original base when bit 4 = 1 (post-update). No other form raises `wb_en`.
- R4: Bits 7:5 = 111 with bit 2 = 0 and bits 2:0 not equal to 011 select the extended offset forms, with base = bits 4:3 (same encoding as R1). When bit 1 = 1, two extension bytes are fetched, high byte first, and added to the base. When bit 1 = 0, one byte is fetched and added to the base; it is extended with 0xFF above it when bit 0 = 1 and with 0x00 when bit 0 = 0.
- R5: Bits 7:5 = 111 with bit 2 = 1 select accumulator offsets, with base = bits 4:3. Bits 1:0 give the offset: 00 is A zero-extended, 01 is B zero-extended, and 10 is D = {A,B}. No fetch and no read take place.
- R6: Bits 7:5 = 111 with bits 2:0 = 011 select the 16-bit indirect form. Two extension bytes are fetched, high byte first, and added to the base from bits 4:3. One 16-bit word is then read at that sum, and the word read becomes the effective address.
- R7: Bits 7:5 = 111 with bits 2:0 = 111 select D-indirect. One 16-bit word is read at base + D, and that word becomes the effective address.
- R8: When `restricted` = 1, the 9-bit, 16-bit and 16-bit indirect forms are rejected. A rejected form completes with effective address 0, no fetch, no read, no write-back and `extra_cycle` = 0, and `done` is high in the cycle after `start`.
- R9: `extra_cycle` is high with `done` for the 9-bit, 16-bit, 16-bit indirect and D-indirect forms, and low for all other forms.
- R10: The port handshakes are held until accepted. `fetch_req` stays high until a cycle with `fetch_ack`. `mem_req` and `mem_addr` stay unchanged until a cycle with `mem_ack`. Exactly as many fetches and reads occur as each form requires.
- R11: After reset, `done`, `fetch_req` and `mem_req` are low. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding the postbyte (used in IDLE only) |
| postbyte | input | 8 | Indexed-addressing postbyte |
| restricted | input | 1 | Reject the extended offset and 16-bit indirect forms |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| fetch_req | output | 1 | Request for the next extension byte |
| fetch_ack | input | 1 | Extension byte valid this cycle |
| fetch_byte | input | 8 | Extension byte |
| mem_req | output | 1 | Request for a 16-bit indirect read |
| mem_addr | output | 16 | Indirect read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_data | input | 16 | Read data |
| done | output | 1 | Result valid (one cycle) |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Index register write-back enable |
| wb_sel | output | 2 | Index register to write (0 X, 1 Y, 2 SP, 3 PC) |
| wb_value | output | 16 | Updated index register value |
| extra_cycle | output | 1 | Form costs one extra cycle |

## Verification
The embedded properties check the port-level rules on every cycle:
- a pending fetch or read request is held;
- the read address is held until `mem_ack`;
- `done` is a single-cycle pulse;
- a rejected form finishes at once with address 0;
- an indirect result equals the word delivered in the previous cycle.

The decode itself can only be shown by the bench's sweep. The sweep covers every postbyte, in both modes, across several register sets chosen so that sums wrap at 2^16. It also covers the signed 5-bit, step and byte extensions, the extension byte order, and the fetch and read counts, all under randomly stalled acknowledges.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [2:0] {
        FORM_OFF5,
        FORM_AUTO,
        FORM_OFF9,
        FORM_OFF16,
        FORM_IND16,
        FORM_ACC,
        FORM_ACCIND,
        FORM_REJECT
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_READ,
        ST_DONE
    } state_e;

    typedef struct packed {
        form_e             form;
        logic [SEL_W-1:0]  base_sel;
        logic              post;
        logic [ADDR_W-1:0] init_off;
    } decode_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_agen_pkg::*;
(
    input  logic [BYTE_W-1:0] postbyte,
    input  logic              restricted,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output decode_t           dec
);
    localparam int SHORT_W = 5;
    localparam int STEP_W  = 4;

    always_comb begin
        dec          = '0;
        dec.form     = FORM_OFF5;
        dec.base_sel = postbyte[7:6];
        dec.post     = 1'b0;
        dec.init_off = {{(ADDR_W-SHORT_W){postbyte[4]}}, postbyte[SHORT_W-1:0]};
        if (!postbyte[5]) begin
            dec.form = FORM_OFF5;
        end else if (postbyte[7:6] != 2'b11) begin
            dec.form = FORM_AUTO;
            dec.post = postbyte[4];
            if (postbyte[3])
                dec.init_off = {{(ADDR_W-STEP_W){1'b1}}, postbyte[STEP_W-1:0]};
            else
                dec.init_off = {{(ADDR_W-STEP_W){1'b0}}, postbyte[STEP_W-1:0]} + 1'b1;
        end else begin
            dec.base_sel = postbyte[4:3];
            if (postbyte[2:0] == 3'b011) begin
                dec.form     = restricted ? FORM_REJECT : FORM_IND16;
                dec.init_off = '0;
            end else if (!postbyte[2]) begin
                if (postbyte[1]) begin
                    dec.form     = restricted ? FORM_REJECT : FORM_OFF16;
                    dec.init_off = '0;
                end else begin
                    dec.form     = restricted ? FORM_REJECT : FORM_OFF9;
                    dec.init_off = {{(ADDR_W-BYTE_W){postbyte[0]}}, {BYTE_W{1'b0}}};
                end
            end else begin
                unique case (postbyte[1:0])
                    2'b00: begin
                        dec.form     = FORM_ACC;
                        dec.init_off = {{(ADDR_W-BYTE_W){1'b0}}, acc_a};
                    end
                    2'b01: begin
                        dec.form     = FORM_ACC;
                        dec.init_off = {{(ADDR_W-BYTE_W){1'b0}}, acc_b};
                    end
                    2'b10: begin
                        dec.form     = FORM_ACC;
                        dec.init_off = {acc_a, acc_b};
                    end
                    default: begin
                        dec.form     = FORM_ACCIND;
                        dec.init_off = {acc_a, acc_b};
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/idx_seq.sv
module idx_seq
    import idx_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  decode_t           dec,
    input  logic [ADDR_W-1:0] base_val,
    output logic              fetch_req,
    input  logic              fetch_ack,
    input  logic [BYTE_W-1:0] fetch_byte,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_data,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [ADDR_W-1:0] wb_value,
    output logic              extra_cycle
);
    state_e            state_q, state_d;
    form_e             form_q;
    logic [SEL_W-1:0]  sel_q;
    logic              post_q;
    logic [ADDR_W-1:0] base_q, off_q, ind_q;
    logic [ADDR_W-1:0] sum;

    assign sum = base_q + off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (dec.form)
                        FORM_OFF9:              state_d = ST_FETCH_LO;
                        FORM_OFF16, FORM_IND16: state_d = ST_FETCH_HI;
                        FORM_ACCIND:            state_d = ST_READ;
                        default:                state_d = ST_DONE;
                    endcase
                end
            end
            ST_FETCH_HI: if (fetch_ack) state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (fetch_ack) state_d = (form_q == FORM_IND16) ? ST_READ : ST_DONE;
            ST_READ:     if (mem_ack)   state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            form_q <= FORM_OFF5;
            sel_q  <= '0;
            post_q <= 1'b0;
            base_q <= '0;
            off_q  <= '0;
            ind_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                form_q <= dec.form;
                sel_q  <= dec.base_sel;
                post_q <= dec.post;
                base_q <= base_val;
                off_q  <= dec.init_off;
            end
            if (state_q == ST_FETCH_HI && fetch_ack)
                off_q[ADDR_W-1 -: BYTE_W] <= fetch_byte;
            if (state_q == ST_FETCH_LO && fetch_ack)
                off_q[BYTE_W-1:0] <= fetch_byte;
            if (state_q == ST_READ && mem_ack)
                ind_q <= mem_data;
        end
    end

    always_comb begin
        fetch_req   = 1'b0;
        mem_req     = 1'b0;
        mem_addr    = sum;
        done        = 1'b0;
        ea          = '0;
        wb_en       = 1'b0;
        wb_sel      = sel_q;
        wb_value    = sum;
        extra_cycle = 1'b0;
        unique case (state_q)
            ST_FETCH_HI, ST_FETCH_LO: fetch_req = 1'b1;
            ST_READ:                  mem_req   = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                unique case (form_q)
                    FORM_AUTO:               begin ea = post_q ? base_q : sum; wb_en = 1'b1; end
                    FORM_IND16, FORM_ACCIND: begin ea = ind_q; extra_cycle = 1'b1; end
                    FORM_OFF9, FORM_OFF16:   begin ea = sum; extra_cycle = 1'b1; end
                    FORM_REJECT:             ea = '0;
                    default:                 ea = sum;
                endcase
            end
            default: ;
        endcase
    end

    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> fetch_req);

    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_reject_quick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && dec.form == FORM_REJECT)
        |=> (done && ea == '0 && !wb_en && !extra_cycle));

    assert_indirect_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (form_q == FORM_IND16 || form_q == FORM_ACCIND))
        |-> ($past(mem_ack) && ea == $past(mem_data)));
endmodule

// File: rtl/idx_agen.sv
module idx_agen
    import idx_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] postbyte,
    input  logic              restricted,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic              fetch_req,
    input  logic              fetch_ack,
    input  logic [BYTE_W-1:0] fetch_byte,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_data,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [ADDR_W-1:0] wb_value,
    output logic              extra_cycle
);
    decode_t           dec;
    logic [ADDR_W-1:0] base_val;

    idx_decode u_decode (
        .postbyte   (postbyte),
        .restricted (restricted),
        .acc_a      (acc_a),
        .acc_b      (acc_b),
        .dec        (dec)
    );

    always_comb begin
        unique case (dec.base_sel)
            2'd0:    base_val = reg_x;
            2'd1:    base_val = reg_y;
            2'd2:    base_val = reg_sp;
            default: base_val = reg_pc;
        endcase
    end

    idx_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec         (dec),
        .base_val    (base_val),
        .fetch_req   (fetch_req),
        .fetch_ack   (fetch_ack),
        .fetch_byte  (fetch_byte),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_data    (mem_data),
        .done        (done),
        .ea          (ea),
        .wb_en       (wb_en),
        .wb_sel      (wb_sel),
        .wb_value    (wb_value),
        .extra_cycle (extra_cycle)
    );
endmodule

// File: tb/test_idx_agen.sv
`timescale 1ns/1ps
module test_idx_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        restricted = 1'b0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        fetch_req, fetch_ack;
    logic [7:0]  fetch_byte;
    logic        mem_req, mem_ack;
    logic [15:0] mem_addr, mem_data;
    logic        done, wb_en, extra_cycle;
    logic [15:0] ea, wb_value;
    logic [1:0]  wb_sel;

    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  e0 = '0, e1 = '0;
    int          fcnt = 0, rcnt = 0;
    int          nchk = 0, nfail = 0;
    string       tag;
    logic [15:0] exp_ea, exp_wbv;
    logic        exp_wb, exp_x;
    logic [1:0]  exp_sel;
    int          exp_nf, exp_nr;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] memfun(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction

    assign fetch_ack  = fetch_req & lfsr[0];
    assign mem_ack    = mem_req & lfsr[1];
    assign fetch_byte = (fcnt == 0) ? e0 : e1;
    assign mem_data   = memfun(mem_addr);

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    always @(posedge clk) begin
        if (start) begin
            fcnt <= 0;
            rcnt <= 0;
        end else begin
            if (fetch_req && fetch_ack) fcnt <= fcnt + 1;
            if (mem_req && mem_ack)     rcnt <= rcnt + 1;
        end
    end

    idx_agen i_idx_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte), .restricted(restricted),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .acc_a(acc_a), .acc_b(acc_b),
        .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_byte(fetch_byte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value),
        .extra_cycle(extra_cycle)
    );

    task automatic chk(input bit ok, input string what, input logic [15:0] got, input logic [15:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s got=%h exp=%h pb=%h rs=%0d", tag, what, got, expv, postbyte, restricted);
        end
    endtask

    function automatic logic [15:0] pick(input logic [1:0] s);
        case (s)
            2'd0: return reg_x;
            2'd1: return reg_y;
            2'd2: return reg_sp;
            default: return reg_pc;
        endcase
    endfunction

    task automatic model(input logic [7:0] pb, input logic rs);
        int o;
        logic [15:0] b;
        logic [15:0] dv;
        dv = {acc_a, acc_b};
        exp_wb = 0; exp_wbv = 0; exp_sel = 0; exp_nf = 0; exp_nr = 0; exp_x = 0;
        if (!pb[5]) begin
            tag = "R1";
            b = pick(pb[7:6]);
            o = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
            exp_ea = b + 16'(o);
        end else if (pb[7:6] != 2'b11) begin
            tag = "R2 R3";
            b = pick(pb[7:6]);
            o = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
            exp_wb = 1; exp_sel = pb[7:6];
            exp_wbv = b + 16'(o);
            exp_ea = pb[4] ? b : exp_wbv;
        end else begin
            b = pick(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                if (rs) begin tag = "R8"; exp_ea = 0; end
                else begin
                    tag = "R6"; exp_nf = 2; exp_nr = 1; exp_x = 1;
                    exp_ea = memfun(b + {e0, e1});
                end
            end else if (!pb[2]) begin
                if (rs) begin tag = "R8"; exp_ea = 0; end
                else if (pb[1]) begin
                    tag = "R4"; exp_nf = 2; exp_x = 1; exp_ea = b + {e0, e1};
                end else begin
                    tag = "R4"; exp_nf = 1; exp_x = 1;
                    o = int'(e0) - (pb[0] ? 256 : 0);
                    exp_ea = b + 16'(o);
                end
            end else begin
                case (pb[1:0])
                    2'd0: begin tag = "R5"; exp_ea = b + {8'h00, acc_a}; end
                    2'd1: begin tag = "R5"; exp_ea = b + {8'h00, acc_b}; end
                    2'd2: begin tag = "R5"; exp_ea = b + dv; end
                    default: begin tag = "R7"; exp_nr = 1; exp_x = 1; exp_ea = memfun(b + dv); end
                endcase
            end
        end
    endtask

    task automatic run(input logic [7:0] pb, input logic rs, input int set);
        int cnt;
        @(negedge clk);
        postbyte = pb; restricted = rs;
        e0 = pb ^ 8'hA5 ^ 8'(set * 17);
        e1 = pb + 8'h3C + 8'(set);
        model(pb, rs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 60) begin
            @(negedge clk);
            cnt++;
        end
        chk(done == 1'b1, "done seen", 16'(done), 16'd1);
        if (rs && tag == "R8")
            chk(cnt == 0, "R8 immediate done latency", 16'(cnt), 16'd0);
        chk(ea == exp_ea, "ea", ea, exp_ea);
        chk(wb_en == exp_wb, "R3 wb_en", 16'(wb_en), 16'(exp_wb));
        if (exp_wb)
            chk(wb_value == exp_wbv && wb_sel == exp_sel, "R3 wb_value/wb_sel", wb_value, exp_wbv);
        chk(extra_cycle == exp_x, "R9 extra_cycle", 16'(extra_cycle), 16'(exp_x));
        chk(fcnt == exp_nf && rcnt == exp_nr, "R10 fetch/read count",
            16'(fcnt * 16 + rcnt), 16'(exp_nf * 16 + exp_nr));
        @(negedge clk);
        chk(done == 1'b0, "R11 done pulse", 16'(done), 16'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tag = "WD";
        nchk++; nfail++;
        $display("FAIL watchdog timeout");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        tag = "R11";
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && fetch_req == 1'b0 && mem_req == 1'b0, "R11 reset outputs",
            {13'd0, done, fetch_req, mem_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && fetch_req == 1'b0 && mem_req == 1'b0, "R11 idle after reset",
            {13'd0, done, fetch_req, mem_req}, 16'd0);
        for (int s = 0; s < 3; s++) begin
            case (s)
                0: begin reg_x = 16'h1234; reg_y = 16'h8000; reg_sp = 16'h0FF0; reg_pc = 16'hC000; acc_a = 8'h80; acc_b = 8'h7F; end
                1: begin reg_x = 16'hFFFF; reg_y = 16'h0000; reg_sp = 16'hFFF8; reg_pc = 16'h0005; acc_a = 8'hFF; acc_b = 8'h01; end
                default: begin reg_x = 16'h0007; reg_y = 16'h7FFC; reg_sp = 16'h2000; reg_pc = 16'hFFFE; acc_a = 8'h00; acc_b = 8'hFF; end
            endcase
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 256; p++) begin
                    run(8'(p), r[0], s);
                end
            end
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule